// File: doc/BRIEF.md
# Masked Packed Unsigned Maximum Unit

This SIMD datapath unit takes two vector operands, splits them into lanes, compares each pair of lanes as unsigned integers and writes the larger value into the matching lane of a new destination vector. Lanes are 32 or 64 bits wide. The active vector length is 128, 256 or 512 bits out of a 512-bit register. A mode input selects one of three operating styles. The legacy two-operand style takes its first source from the old destination and leaves the upper register bits untouched. The plain three-operand style clears every bit above the active length. The masked style adds per-lane write enables with merge or zero handling, 64-bit lanes, and broadcast of a single element of the second operand.

The caller presents both sources, the old destination value, a 16-bit mask and the mode controls, and pulses `in_valid`. The new destination appears one clock later together with `out_valid`. There is no backpressure. The operation never produces arithmetic status.

Top module: `umax_unit`

## Requirements
- R1: For each active lane, the result is the first source element when it is strictly greater, as an unsigned number, than the second source element. Otherwise the result is the second source element. Equal inputs give that same value.
- R2: With 64-bit lanes (masked style, `wide_lanes`=1), each lane compares all 64 bits. A difference only in bits 63:32 decides the result.
- R3: In the masked style, `vlen_sel` 0/1/2 selects 128/256/512 bits, and 3 also selects 512. This gives 4/8/16 lanes of 32 bits or 2/4/8 lanes of 64 bits. Destination bits from the active length up to bit 511 become zero.
- R4: In the masked style with `mask_en`=1, lane j is computed only when `mask[j]` is 1. With `mask_en`=0, every lane within the length is computed.
- R5: An inactive lane (mask bit 0) keeps its `dest_old` value when `zero_inactive`=0 and becomes zero when `zero_inactive`=1.
- R6: In the masked style with `bcast`=1 and `src2_mem`=1, bits 31:0 of `src_b` (or bits 63:0 for 64-bit lanes) are compared against every lane of `src_a`. When `src2_mem`=0, `bcast` has no effect.
- R7: Legacy style (`mode`=0): the first source is `dest_old` and `src_a` is ignored. The length is 128 bits with 32-bit lanes. `dest_new[511:128]` equals `dest_old[511:128]`. The mask, `wide_lanes` and `bcast` are ignored.
- R8: Plain style (`mode`=1): lanes are 32 bits. `vlen_sel`=0 selects 128 bits and any other value selects 256 bits. Bits above the length are cleared. The mask, `wide_lanes` and `bcast` are ignored.
- R9: Mask bits at or above the lane count of the selected configuration have no effect on the result.
- R10: `dest_new` and `out_valid` are registered. They update on the clock edge that samples `in_valid`=1. `dest_new` holds while `in_valid`=0, and reset clears both to zero. `mode`=3 behaves as `mode`=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| mode | input | 2 | 0 legacy, 1 plain, 2 or 3 masked |
| vlen_sel | input | 2 | Vector length select: 0 is 128, 1 is 256, 2 or 3 is 512 bits |
| wide_lanes | input | 1 | 64-bit lanes (masked style only) |
| mask_en | input | 1 | Apply the per-lane mask (masked style only) |
| zero_inactive | input | 1 | 1 zeroes inactive lanes, 0 merges them |
| bcast | input | 1 | Broadcast element 0 of the second operand |
| src2_mem | input | 1 | Second operand comes from memory (enables broadcast) |
| mask | input | 16 | Per-lane enable, bit j for lane j |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dest_old | input | 512 | Previous destination value |
| out_valid | output | 1 | `dest_new` was updated on the last edge |
| dest_new | output | 512 | New destination value |

## Verification
Lane masking and vector-length clearing can act on the same cycle. A mask bit can be set for a lane that lies beyond the active length, and an inactive lane can sit next to the length boundary. The bench provokes this in merge mode by setting every mask bit with a 128-bit length and a nonzero `dest_old`. Every bit above 127 must then read zero, not the merged old value. A second case combines broadcast with zero-masking, so that lanes compared against the broadcast element and zeroed lanes alternate within one result.

// File: rtl/umax_pkg.sv
// Shared definitions for the packed unsigned maximum unit.
// Assumes a 512-bit register split into 32-bit chunks.
package umax_pkg;
    localparam int REG_W   = 512;
    localparam int CHUNK_W = 32;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'd0,
        MODE_PLAIN  = 2'd1,
        MODE_MASKED = 2'd2,
        MODE_MASKX  = 2'd3
    } op_mode_e;
endpackage

// File: rtl/umax_cfg.sv
// Decodes the mode controls into datapath enables and an active chunk count.
// Assumes the control inputs are stable while in_valid is high.
module umax_cfg
    import umax_pkg::*;
#(
    parameter int CW      = 32,
    parameter int N_CHUNK = 16,
    parameter int CNT_W   = $clog2(N_CHUNK) + 1
) (
    input  logic [1:0]       mode,
    input  logic [1:0]       vlen_sel,
    input  logic             wide_lanes,
    input  logic             mask_en,
    input  logic             bcast,
    input  logic             src2_mem,
    output logic             wide_eff,
    output logic             mask_on,
    output logic             bcast_on,
    output logic             keep_upper,
    output logic             first_from_dest,
    output logic [CNT_W-1:0] chunk_limit
);
    localparam int C128 = 128 / CW;
    localparam int C256 = 256 / CW;
    localparam int C512 = 512 / CW;

    op_mode_e md;

    // Decode the style into per-feature enables and the active length.
    always_comb begin
        md              = op_mode_e'(mode);
        wide_eff        = 1'b0;
        mask_on         = 1'b0;
        bcast_on        = 1'b0;
        keep_upper      = 1'b0;
        first_from_dest = 1'b0;
        chunk_limit     = CNT_W'(C128);
        case (md)
            MODE_LEGACY: begin
                keep_upper      = 1'b1;
                first_from_dest = 1'b1;
            end
            MODE_PLAIN: begin
                chunk_limit = (vlen_sel == 2'd0) ? CNT_W'(C128) : CNT_W'(C256);
            end
            default: begin
                wide_eff = wide_lanes;
                mask_on  = mask_en;
                bcast_on = bcast & src2_mem;
                case (vlen_sel)
                    2'd0:    chunk_limit = CNT_W'(C128);
                    2'd1:    chunk_limit = CNT_W'(C256);
                    default: chunk_limit = CNT_W'(C512);
                endcase
            end
        endcase
    end
endmodule

// File: rtl/umax_slice.sv
// One 64-bit compare slice: either a single 64-bit unsigned max or two
// independent 32-bit unsigned maxes, chosen by `wide`.
// Assumes SW is even; purely combinational.
module umax_slice #(
    parameter int SW = 64,
    parameter int HW = SW / 2
) (
    input  logic [SW-1:0] a,
    input  logic [SW-1:0] b,
    input  logic          wide,
    output logic [SW-1:0] res
);
    logic [HW-1:0] lo_max, hi_max;
    logic [SW-1:0] full_max;

    // Form both narrow maxes and the full-width max, then pick by lane size.
    always_comb begin
        lo_max   = (a[HW-1:0]  > b[HW-1:0])  ? a[HW-1:0]  : b[HW-1:0];
        hi_max   = (a[SW-1:HW] > b[SW-1:HW]) ? a[SW-1:HW] : b[SW-1:HW];
        full_max = (a > b) ? a : b;
        res      = wide ? full_max : {hi_max, lo_max};
    end

    // Check that the chosen result dominates both inputs at the selected lane size.
    always_comb begin
        if (wide) begin
            // R2
            wide_dom_chk: assert (res >= a && res >= b && (res == a || res == b));
        end else begin
            // R1
            narrow_dom_chk: assert (res[HW-1:0] >= a[HW-1:0] && res[HW-1:0] >= b[HW-1:0]
                                    && res[SW-1:HW] >= a[SW-1:HW] && res[SW-1:HW] >= b[SW-1:HW]);
        end
    end
endmodule

// File: rtl/umax_chunk_sel.sv
// Final selection for one 32-bit destination chunk: the computed max,
// the old value, or zero, by length range and lane mask.
// Assumes in_range and lane_on are already decoded for this chunk.
module umax_chunk_sel #(
    parameter int CW = 32
) (
    input  logic [CW-1:0] max_val,
    input  logic [CW-1:0] old_val,
    input  logic          lane_on,
    input  logic          in_range,
    input  logic          keep_upper,
    input  logic          zero_inactive,
    output logic [CW-1:0] res
);
    // Out-of-range chunks follow the upper-bit policy; in-range ones follow the mask.
    always_comb begin
        if (!in_range)
            res = keep_upper ? old_val : '0;
        else if (lane_on)
            res = max_val;
        else if (zero_inactive)
            res = '0;
        else
            res = old_val;
    end
endmodule

// File: rtl/umax_unit.sv
// Masked packed unsigned maximum unit. Compares src lanes as unsigned,
// applies mask, broadcast and upper-bit policy, and registers the result.
// Assumes a 512-bit register and a 16-bit mask; no backpressure.
module umax_unit
    import umax_pkg::*;
#(
    parameter int VEC_W = REG_W,
    parameter int CW    = CHUNK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         mode,
    input  logic [1:0]         vlen_sel,
    input  logic               wide_lanes,
    input  logic               mask_en,
    input  logic               zero_inactive,
    input  logic               bcast,
    input  logic               src2_mem,
    input  logic [15:0]        mask,
    input  logic [VEC_W-1:0]   src_a,
    input  logic [VEC_W-1:0]   src_b,
    input  logic [VEC_W-1:0]   dest_old,
    output logic               out_valid,
    output logic [VEC_W-1:0]   dest_new
);
    localparam int N_CHUNK = VEC_W / CW;
    localparam int SW      = 2 * CW;
    localparam int N_SLICE = VEC_W / SW;
    localparam int CNT_W   = $clog2(N_CHUNK) + 1;

    logic             wide_eff, mask_on, bcast_on, keep_upper, first_from_dest;
    logic [CNT_W-1:0] chunk_limit;
    logic [VEC_W-1:0] max_vec, next_dest;
    logic [SW-1:0]    bcast_val;

    umax_cfg #(.CW(CW), .N_CHUNK(N_CHUNK), .CNT_W(CNT_W)) u_cfg (
        .mode            (mode),
        .vlen_sel        (vlen_sel),
        .wide_lanes      (wide_lanes),
        .mask_en         (mask_en),
        .bcast           (bcast),
        .src2_mem        (src2_mem),
        .wide_eff        (wide_eff),
        .mask_on         (mask_on),
        .bcast_on        (bcast_on),
        .keep_upper      (keep_upper),
        .first_from_dest (first_from_dest),
        .chunk_limit     (chunk_limit)
    );

    // Replicate element 0 of the second operand to fill one slice.
    always_comb begin
        bcast_val = wide_eff ? src_b[SW-1:0] : {2{src_b[CW-1:0]}};
    end

    for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
        logic [SW-1:0] a_sl, b_sl;
        // Choose the operands of this slice.
        always_comb begin
            a_sl = first_from_dest ? dest_old[s*SW +: SW] : src_a[s*SW +: SW];
            b_sl = bcast_on ? bcast_val : src_b[s*SW +: SW];
        end
        umax_slice #(.SW(SW)) u_slice (
            .a    (a_sl),
            .b    (b_sl),
            .wide (wide_eff),
            .res  (max_vec[s*SW +: SW])
        );
    end

    for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
        logic lane_on, in_range;
        // Decode this chunk's mask bit and length range.
        always_comb begin
            lane_on  = !mask_on || (wide_eff ? mask[c/2] : mask[c]);
            in_range = (CNT_W'(c) < chunk_limit);
        end
        umax_chunk_sel #(.CW(CW)) u_sel (
            .max_val       (max_vec[c*CW +: CW]),
            .old_val       (dest_old[c*CW +: CW]),
            .lane_on       (lane_on),
            .in_range      (in_range),
            .keep_upper    (keep_upper),
            .zero_inactive (zero_inactive),
            .res           (next_dest[c*CW +: CW])
        );
    end

    // Register the result and its valid flag; hold the result while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dest_new  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                dest_new <= next_dest;
        end
    end

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dest_new)));

    // R7
    legacy_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0) |=> dest_new[VEC_W-1:128] == $past(dest_old[VEC_W-1:128]));

    // R8
    plain_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=> dest_new[VEC_W-1:256] == '0);

    // R5
    zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && mask_en && zero_inactive && mask == 16'h0) |=> dest_new == '0);

    // R3
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode[1] && vlen_sel == 2'd0) |=> dest_new[VEC_W-1:128] == '0);
endmodule

// File: tb/sim_umax_unit.sv
`timescale 1ns/1ps
module sim_umax_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [1:0]   mode, vlen_sel;
    logic         wide_lanes, mask_en, zero_inactive, bcast, src2_mem;
    logic [15:0]  mask;
    logic [511:0] src_a, src_b, dest_old;
    logic         out_valid;
    logic [511:0] dest_new;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    umax_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .vlen_sel(vlen_sel),
        .wide_lanes(wide_lanes), .mask_en(mask_en), .zero_inactive(zero_inactive),
        .bcast(bcast), .src2_mem(src2_mem), .mask(mask), .src_a(src_a), .src_b(src_b),
        .dest_old(dest_old), .out_valid(out_valid), .dest_new(dest_new)
    );

    // Expected result computed from the requirements.
    function automatic logic [511:0] model(input logic [1:0] md, input logic [1:0] vs,
        input logic wd, input logic men, input logic zi, input logic bc, input logic mem,
        input logic [15:0] m, input logic [511:0] a, input logic [511:0] b, input logic [511:0] d);
        logic [511:0] r, s1;
        int vl, ew;
        bit w, use_m, bon;
        s1    = (md == 2'd0) ? d : a;
        w     = md[1] && wd;
        ew    = w ? 64 : 32;
        use_m = md[1] && men;
        bon   = md[1] && bc && mem;
        if (md == 2'd0) vl = 128;
        else if (md == 2'd1) vl = (vs == 2'd0) ? 128 : 256;
        else vl = (vs == 2'd0) ? 128 : (vs == 2'd1) ? 256 : 512;
        r = (md == 2'd0) ? d : '0;
        for (int j = 0; j < vl / ew; j++) begin
            logic [63:0] x, y, z, o;
            x = 64'(s1 >> (j * ew));
            y = bon ? b[63:0] : 64'(b >> (j * ew));
            o = 64'(d >> (j * ew));
            if (!w) begin x[63:32] = '0; y[63:32] = '0; o[63:32] = '0; end
            z = (x > y) ? x : y;
            if (use_m && !m[j]) z = zi ? 64'd0 : o;
            for (int k = 0; k < ew; k++) r[j * ew + k] = z[k];
        end
        return r;
    endfunction

    function automatic logic [511:0] pat(input logic [31:0] seed);
        logic [511:0] v;
        logic [31:0]  x;
        x = seed;
        for (int k = 0; k < 16; k++) begin
            x = x * 32'h0019660D + 32'h3C6EF35F;
            v[k*32 +: 32] = x ^ {x[15:0], x[31:16]};
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 0; mode = 0; vlen_sel = 0; wide_lanes = 0; mask_en = 0;
        zero_inactive = 0; bcast = 0; src2_mem = 0; mask = 0;
        src_a = '0; src_b = '0; dest_old = '0;
    endtask

    // Drive one operation and compare the registered result one edge later.
    task automatic run(input string req, input logic [1:0] md, input logic [1:0] vs,
        input logic wd, input logic men, input logic zi, input logic bc, input logic mem,
        input logic [15:0] m, input logic [511:0] a, input logic [511:0] b, input logic [511:0] d);
        logic [511:0] exp;
        exp = model(md, vs, wd, men, zi, bc, mem, m, a, b, d);
        @(negedge clk);
        in_valid = 1; mode = md; vlen_sel = vs; wide_lanes = wd; mask_en = men;
        zero_inactive = zi; bcast = bc; src2_mem = mem; mask = m;
        src_a = a; src_b = b; dest_old = d;
        @(negedge clk);
        in_valid = 0;
        check(req, dest_new, exp);
        check({req, " valid"}, {511'd0, out_valid}, 512'd1);
    endtask

    task automatic t_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R10 reset data", dest_new, '0);
        check("R10 reset valid", {511'd0, out_valid}, 512'd0);
        rst_n = 1;
    endtask

    // R1: 32-bit lanes with strict-greater, equal and extreme values.
    task automatic t_basic32();
        logic [511:0] a, b;
        a = pat(32'd1); b = pat(32'd2);
        a[31:0] = 32'hFFFF_FFFF; b[31:0] = 32'h0000_0000;
        a[63:32] = 32'h1234_5678; b[63:32] = 32'h1234_5678;
        a[95:64] = 32'h7FFF_FFFF; b[95:64] = 32'h8000_0000;
        run("R1 masked 512 unmasked", 2'd2, 2'd2, 0, 0, 0, 0, 0, 16'h0, a, b, pat(32'd3));
    endtask

    // R2: 64-bit lanes decided only by upper halves.
    task automatic t_wide64();
        logic [511:0] a, b;
        a = pat(32'd4); b = a;
        for (int s = 0; s < 8; s++) begin
            a[s*64 +: 64] = {32'h0000_0002, 32'h0000_0001};
            b[s*64 +: 64] = {32'h0000_0001, 32'hFFFF_FFFF};
        end
        run("R2 wide upper half", 2'd2, 2'd2, 1, 0, 0, 0, 0, 16'h0, a, b, pat(32'd5));
    endtask

    // R3: each vector length clears above itself.
    task automatic t_lengths();
        run("R3 len128", 2'd2, 2'd0, 0, 0, 0, 0, 0, 16'h0, pat(32'd6), pat(32'd7), pat(32'd8));
        run("R3 len256 wide", 2'd2, 2'd1, 1, 0, 0, 0, 0, 16'h0, pat(32'd9), pat(32'd10), pat(32'd11));
        run("R3 len sel3", 2'd3, 2'd3, 0, 0, 0, 0, 0, 16'h0, pat(32'd12), pat(32'd13), pat(32'd14));
    endtask

    // R4 R5: masked lanes with merge and zero.
    task automatic t_mask();
        run("R4 R5 merge", 2'd2, 2'd2, 0, 1, 0, 0, 0, 16'hA5C3, pat(32'd15), pat(32'd16), pat(32'd17));
        run("R4 R5 zero", 2'd2, 2'd2, 0, 1, 1, 0, 0, 16'h3C5A, pat(32'd18), pat(32'd19), pat(32'd20));
        run("R5 wide merge", 2'd2, 2'd2, 1, 1, 0, 0, 0, 16'h0096, pat(32'd21), pat(32'd22), pat(32'd23));
    endtask

    // R6: broadcast from memory, and broadcast ignored for a register source.
    task automatic t_bcast();
        logic [511:0] b;
        b = pat(32'd24); b[31:0] = 32'h8000_0000;
        run("R6 bcast32 zero-mask", 2'd2, 2'd2, 0, 1, 1, 1, 1, 16'h5555, pat(32'd25), b, pat(32'd26));
        run("R6 bcast64", 2'd2, 2'd1, 1, 0, 0, 1, 1, 16'h0, pat(32'd27), pat(32'd28), pat(32'd29));
        run("R6 bcast reg ignored", 2'd2, 2'd2, 0, 0, 0, 1, 0, 16'h0, pat(32'd30), b, pat(32'd31));
    endtask

    // R7: legacy style uses dest_old as first source and keeps upper bits.
    task automatic t_legacy();
        run("R7 legacy", 2'd0, 2'd2, 1, 1, 1, 1, 1, 16'h0000, pat(32'd32), pat(32'd33), pat(32'd34));
        run("R7 legacy src_a ignored", 2'd0, 2'd0, 0, 0, 0, 0, 0, 16'h0, '1, pat(32'd33), pat(32'd34));
    endtask

    // R8: plain style forces 32-bit lanes, no mask, and caps at 256 bits.
    task automatic t_plain();
        run("R8 plain 128", 2'd1, 2'd0, 1, 1, 1, 1, 1, 16'h0, pat(32'd35), pat(32'd36), pat(32'd37));
        run("R8 plain sel2 as 256", 2'd1, 2'd2, 0, 1, 0, 0, 0, 16'h0, pat(32'd38), pat(32'd39), pat(32'd40));
    endtask

    // R9: mask bits beyond the lane count, combined with length clearing.
    task automatic t_high_mask();
        run("R9 high mask len128", 2'd2, 2'd0, 0, 1, 0, 0, 0, 16'hFFFF, pat(32'd41), pat(32'd42), pat(32'd43));
        run("R9 high mask wide", 2'd2, 2'd1, 1, 1, 0, 0, 0, 16'hFFF0, pat(32'd44), pat(32'd45), pat(32'd46));
    endtask

    // R10: result holds while in_valid is low even when inputs move.
    task automatic t_hold();
        logic [511:0] snap;
        run("R10 pre-hold", 2'd2, 2'd2, 0, 0, 0, 0, 0, 16'h0, pat(32'd47), pat(32'd48), pat(32'd49));
        snap = dest_new;
        @(negedge clk);
        src_a = pat(32'd50); src_b = '1; dest_old = pat(32'd51); mode = 2'd1;
        repeat (2) @(negedge clk);
        check("R10 hold data", dest_new, snap);
        check("R10 hold valid", {511'd0, out_valid}, 512'd0);
    endtask

    initial begin
        t_reset();
        t_basic32();
        t_wide64();
        t_lengths();
        t_mask();
        t_bcast();
        t_legacy();
        t_plain();
        t_high_mask();
        t_hold();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule